// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block is a single performance-monitor counter channel. On every clock it receives a small binary number: how many events of one kind occurred in that cycle. The counter compares that number with a programmable threshold, using one of four comparison modes. When the comparison holds, the counter adds either the whole per-cycle number or exactly one to a wide wrapping accumulator. When it fails, the accumulator does not change.

A threshold of zero turns the qualification off. In that case the counter adds the per-cycle number on every enabled cycle, and the comparison mode and add-one flag are ignored. The block has an enable, a synchronous clear and a one-cycle wrap pulse. It is meant to sit behind an event-select multiplexer, and its accumulator output is read directly.

Top module: `thresh_event_counter`

## Requirements
- R1: After reset the accumulator reads 0 and the wrap pulse is low.
- R2: With threshold 0, every enabled cycle adds the per-cycle count, whatever the values of `cmp_sel` and `add_one`.
- R3: With a nonzero threshold, `cmp_sel` chooses the test of the zero-extended per-cycle count against the threshold: 0 = not equal, 1 = equal, 2 = greater than or equal, 3 = less than.
- R4: With a nonzero threshold and `add_one` low, a cycle that passes the test adds the full per-cycle count.
- R5: With a nonzero threshold and `add_one` high, a cycle that passes the test adds exactly 1. This holds even when the per-cycle count is 0.
- R6: A cycle that fails the test leaves the accumulator unchanged.
- R7: With `en` low and `clr` low, the accumulator holds its value and the wrap pulse stays low.
- R8: `clr` sets the accumulator to 0 at the next edge. It takes priority over `en` and over any increment.
- R9: The accumulator wraps modulo 2^ACC_W. `wrap_pulse` is high for exactly the cycle after an increment that carried out of the top bit.
- R10: The event count and all configuration inputs are used at the edge where they are sampled. There is no extra pipeline stage, so a change affects the very next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable |
| clr | input | 1 | Synchronous accumulator clear |
| evt_cnt | input | EVT_W (4) | Events seen this cycle |
| thresh | input | THR_W (12) | Threshold; 0 disables qualification |
| cmp_sel | input | 2 | Comparison mode |
| add_one | input | 1 | Add 1 instead of the count when qualified |
| acc_q | output | ACC_W (64) | Accumulator value |
| wrap_pulse | output | 1 | One-cycle pulse after a wrap |

## Verification
The assertions assume that every input is a known value at each rising edge and that `rst` is held for at least one edge before counting starts. They relate each accumulator value to the value and inputs captured at the previous edge. The bench meets these conditions: it changes inputs only on the falling edge and holds reset for several cycles. The bench also builds a narrow accumulator so that wraps happen often during a sweep of every mode, add-one setting, a set of thresholds (including ones above the count range) and every per-cycle count.

// File: rtl/tec_pkg.sv
package tec_pkg;

    localparam int EVT_W = 4;
    localparam int THR_W = 12;

    typedef enum logic [1:0] {
        CMP_NE = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GE = 2'd2,
        CMP_LT = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        cmp_mode_e        mode;
        logic             one;
    } tec_cfg_t;

    typedef struct packed {
        logic             vld;
        logic [EVT_W-1:0] amt;
    } tec_inc_t;

    function automatic logic cond_met(cmp_mode_e m, logic [EVT_W-1:0] e,
                                      logic [THR_W-1:0] t);
        logic [THR_W-1:0] ez;
        ez = {{(THR_W-EVT_W){1'b0}}, e};
        case (m)
            CMP_NE:  return ez != t;
            CMP_EQ:  return ez == t;
            CMP_GE:  return ez >= t;
            default: return ez < t;
        endcase
    endfunction

endpackage

// File: rtl/tec_qualifier.sv
module tec_qualifier
    import tec_pkg::*;
(
    input  tec_cfg_t         cfg,
    input  logic [EVT_W-1:0] evt,
    output tec_inc_t         inc
);
    logic bypass;
    logic pass;

    always_comb begin
        bypass = (cfg.thr == '0);
        pass   = bypass || cond_met(cfg.mode, evt, cfg.thr);
        inc.vld = pass;
        if (!bypass && cfg.one)
            inc.amt = EVT_W'(1);
        else
            inc.amt = evt;
    end
endmodule

// File: rtl/tec_accum.sv
module tec_accum
    import tec_pkg::*;
#(
    parameter int ACC_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  tec_inc_t         inc,
    output logic [ACC_W-1:0] acc,
    output logic             wrap
);
    logic [ACC_W:0] sum;

    always_comb begin
        sum = {1'b0, acc} + {{(ACC_W+1-EVT_W){1'b0}}, inc.amt};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc  <= '0;
            wrap <= 1'b0;
        end else if (en && inc.vld) begin
            acc  <= sum[ACC_W-1:0];
            wrap <= sum[ACC_W];
        end else begin
            wrap <= 1'b0;
        end
    end
endmodule

// File: rtl/thresh_event_counter.sv
module thresh_event_counter
    import tec_pkg::*;
#(
    parameter int ACC_W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 clr,
    input  logic [EVT_W-1:0]     evt_cnt,
    input  logic [THR_W-1:0]     thresh,
    input  logic [1:0]           cmp_sel,
    input  logic                 add_one,
    output logic [ACC_W-1:0]     acc_q,
    output logic                 wrap_pulse
);
    tec_cfg_t cfg;
    tec_inc_t inc;

    always_comb begin
        cfg.thr  = thresh;
        cfg.mode = cmp_mode_e'(cmp_sel);
        cfg.one  = add_one;
    end

    tec_qualifier u_qual (
        .cfg (cfg),
        .evt (evt_cnt),
        .inc (inc)
    );

    tec_accum #(.ACC_W(ACC_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .clr  (clr),
        .inc  (inc),
        .acc  (acc_q),
        .wrap (wrap_pulse)
    );
endmodule

// File: rtl/tec_checker.sv
module tec_checker
    import tec_pkg::*;
#(
    parameter int ACC_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             clr,
    input logic [EVT_W-1:0] evt_cnt,
    input logic [THR_W-1:0] thresh,
    input logic             add_one,
    input logic [ACC_W-1:0] acc_q,
    input logic             wrap_pulse
);
    logic             p_valid;
    logic [ACC_W-1:0] p_acc;
    logic             p_en, p_clr, p_one;
    logic [EVT_W-1:0] p_evt;
    logic [THR_W-1:0] p_thr;
    logic [ACC_W-1:0] diff;
    logic [ACC_W-1:0] exp_raw;

    always_ff @(posedge clk) begin
        p_valid <= !rst;
        p_acc   <= acc_q;
        p_en    <= en;
        p_clr   <= clr;
        p_one   <= add_one;
        p_evt   <= evt_cnt;
        p_thr   <= thresh;
    end

    always_comb begin
        diff    = acc_q - p_acc;
        exp_raw = p_acc + {{(ACC_W-EVT_W){1'b0}}, p_evt};
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && !wrap_pulse));

    assert_bypass_adds_R2: assert property (@(posedge clk) disable iff (rst)
        (p_valid && p_en && !p_clr && p_thr == '0) |-> acc_q == exp_raw);

    assert_step_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (p_valid && p_en && !p_clr) |-> diff <= ACC_W'((1 << EVT_W) - 1));

    assert_add_one_R5: assert property (@(posedge clk) disable iff (rst)
        (p_valid && p_en && !p_clr && p_one && p_thr != '0) |-> diff <= ACC_W'(1));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (p_valid && !p_en && !p_clr) |-> (acc_q == p_acc && !wrap_pulse));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (p_valid && p_clr) |-> (acc_q == '0 && !wrap_pulse));

    assert_wrap_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (p_valid && wrap_pulse) |-> acc_q < p_acc);
endmodule

bind thresh_event_counter tec_checker #(.ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .clr        (clr),
    .evt_cnt    (evt_cnt),
    .thresh     (thresh),
    .add_one    (add_one),
    .acc_q      (acc_q),
    .wrap_pulse (wrap_pulse)
);

// File: tb/sim_thresh_event_counter.sv
`timescale 1ns/1ps
module sim_thresh_event_counter;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          clr = 1'b0;
    logic [3:0]    evt_cnt = '0;
    logic [11:0]   thresh = '0;
    logic [1:0]    cmp_sel = '0;
    logic          add_one = 1'b0;
    logic [AW-1:0] acc_q;
    logic          wrap_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int exp_acc = 0;
    bit exp_wrap = 0;

    always #4 clk = ~clk;

    thresh_event_counter #(.ACC_W(AW)) u0 (
        .clk(clk), .rst(rst), .en(en), .clr(clr), .evt_cnt(evt_cnt),
        .thresh(thresh), .cmp_sel(cmp_sel), .add_one(add_one),
        .acc_q(acc_q), .wrap_pulse(wrap_pulse)
    );

    function automatic bit passes(int m, int e, int t);
        case (m)
            0: return e != t;
            1: return e == t;
            2: return e >= t;
            default: return e < t;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model of one edge using the inputs currently applied
    task automatic model_edge();
        int add;
        bit vld;
        if (rst || clr) begin
            exp_acc = 0; exp_wrap = 0;
        end else if (en) begin
            if (thresh == 0) begin vld = 1; add = evt_cnt; end
            else begin
                vld = passes(cmp_sel, evt_cnt, thresh);
                add = add_one ? 1 : evt_cnt;
            end
            if (vld) begin
                exp_wrap = (exp_acc + add) > 255;
                exp_acc  = (exp_acc + add) % 256;
            end else exp_wrap = 0;
        end else exp_wrap = 0;
    endtask

    task automatic step(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(req, acc_q, exp_acc);
        check("R9", wrap_pulse, exp_wrap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", acc_q, 0);
        check("R1", wrap_pulse, 0);
        rst = 1'b0;
        en  = 1'b1;
        // sweep: inputs change every cycle, so each update uses fresh config (R10)
        foreach (int_thr_list[i]) begin end
        for (int m = 0; m < 4; m++)
            for (int o = 0; o < 2; o++)
                for (int ti = 0; ti < 6; ti++)
                    for (int e = 0; e < 16; e++) begin
                        int t;
                        string tag;
                        case (ti)
                            0: t = 0; 1: t = 1; 2: t = 3;
                            3: t = 7; 4: t = 15; default: t = 20;
                        endcase
                        cmp_sel = 2'(m); add_one = o[0];
                        thresh = 12'(t); evt_cnt = 4'(e);
                        if (t == 0) tag = "R2 R10";
                        else if (!passes(m, e, t)) tag = "R3 R6";
                        else if (o == 1) tag = "R3 R5";
                        else tag = "R3 R4";
                        step(tag);
                    end
        // count of zero passes not-equal and adds one in add-one mode (R5)
        cmp_sel = 2'd0; thresh = 12'd5; add_one = 1'b1; evt_cnt = 4'd0;
        step("R5");
        // hold when disabled (R7)
        en = 1'b0; thresh = 12'd0; evt_cnt = 4'd9;
        step("R7");
        step("R7");
        // clear beats increment and enable (R8)
        en = 1'b1; clr = 1'b1; evt_cnt = 4'd15;
        step("R8");
        en = 1'b0;
        step("R8");
        clr = 1'b0; en = 1'b1;
        // drive to a wrap with raw adds (R9)
        for (int k = 0; k < 20; k++) step("R9");
        // mode switch on consecutive cycles (R10)
        thresh = 12'd4; add_one = 1'b0; evt_cnt = 4'd6;
        cmp_sel = 2'd3; step("R10");
        cmp_sel = 2'd2; step("R10");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    int int_thr_list [1] = '{0};
endmodule